// File: doc/BRIEF.md
# Clock Fault Monitor with Crystal Fallback

This block supervises two clock sources on behalf of a clock system. It watches a low-frequency crystal clock by counting system-clock cycles between its rising edges. It also watches the tap setting of a digitally controlled oscillator (DCO). Each source has its own sticky fault flag. A combined oscillator fault flag stays set while any source flag is set. When interrupts are enabled, the combined flag raises an interrupt request.

If the crystal stops, the low-frequency path moves to an internal reference oscillator. It stays there until software has cleared every flag. A DCO fault on its own leaves the low-frequency path where it is. Software clears the crystal flag with a strobe. That strobe only takes effect once a programmed run of consecutive crystal edges has been seen since the last timeout. All pins are plain control and status signals: no data flows through the block, so there is no valid/ready handshake and no back-pressure. The crystal input is asynchronous and is synchronised inside the block.

Top module: `clk_fault_mon`

## Requirements
- R1: Reset values. Out of reset the crystal flag is 1, the combined flag is 1, the DCO flag is 0 and `lf_sel` is 1, meaning the reference clock is selected. The output `fault_irq` equals `irq_en`.
- R2: The crystal counts as failed when no rising edge arrives for `timeout_cyc` system cycles. In practice, edges spaced P system cycles apart set `xt_fault` if and only if P > `timeout_cyc`. A crystal fault sets `lf_sel` to 1. `timeout_cyc` must be at least 1.
- R3: A `clr_xt` strobe clears `xt_fault` only if at least `good_need` crystal rising edges have arrived since the last timeout. Otherwise the strobe is discarded and is not held pending. `good_need` must be at least 1.
- R4: A timeout resets the count of good crystal edges to zero. Edges seen before a timeout therefore do not count towards a later clear.
- R5: `dco_fault` is set one cycle after `dco_tap <= tap_min` or `dco_tap >= tap_max`. A `clr_dco` strobe clears it only while the tap is strictly between those limits.
- R6: `osc_fault` is set one cycle after either source flag is 1. A `clr_osc` strobe has no effect while either source flag is 1.
- R7: A DCO fault alone never changes `lf_sel`.
- R8: Once `lf_sel` is 1, it returns to 0 (crystal) only one cycle after `xt_fault`, `dco_fault` and `osc_fault` are all 0.
- R9: `fault_irq` is 1 exactly when both `irq_en` and `osc_fault` are 1.
- R10: `lf_clk` carries `ref_clk` while `lf_sel` is 1 and `xt_clk` while `lf_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xt_clk | input | 1 | Low-frequency crystal clock, asynchronous |
| ref_clk | input | 1 | Internal reference oscillator clock |
| dco_tap | input | TAP_W | Current DCO tap setting |
| tap_min | input | TAP_W | Lowest DCO tap |
| tap_max | input | TAP_W | Highest DCO tap |
| timeout_cyc | input | CNT_W | Crystal edge timeout in system cycles |
| good_need | input | GOOD_W | Good crystal edges required before a clear |
| clr_xt | input | 1 | Strobe: clear crystal fault flag |
| clr_dco | input | 1 | Strobe: clear DCO fault flag |
| clr_osc | input | 1 | Strobe: clear combined fault flag |
| irq_en | input | 1 | Fault interrupt enable |
| xt_fault | output | 1 | Crystal fault flag |
| dco_fault | output | 1 | DCO fault flag |
| osc_fault | output | 1 | Combined oscillator fault flag |
| fault_irq | output | 1 | Fault interrupt request |
| lf_sel | output | 1 | 1 = reference selected, 0 = crystal selected |
| lf_clk | output | 1 | Selected low-frequency clock |

## Verification
Crystal edge spacing is swept from 2 to 12 system cycles against a timeout of 6. This separates an off-by-one in the timeout comparison from a correct boundary at P = 6 versus P = 7.

Bursts of 0 to 5 good edges after a timeout, each followed by a clear, separate a correct threshold from an off-by-one threshold. The same sweep shows whether an early clear is stored as pending. A second burst of edges split by a timeout shows whether the good-edge count really restarts.

Every DCO tap value is tried against fixed limits to catch inverted or non-inclusive limit tests. The flag and clear orderings run with both sources at fault. They show whether a remaining DCO fault holds the combined flag and the reference selection, and whether a DCO fault alone moves the path.

// File: rtl/clk_fault_pkg.sv
package clk_fault_pkg;

  // per-source sticky flags
  typedef struct packed {
    logic xt;
    logic dco;
  } src_flags_t;

  function automatic logic any_src(input src_flags_t f);
    return f.xt | f.dco;
  endfunction

endpackage

// File: rtl/cfm_xt_watch.sv
module cfm_xt_watch #(
  parameter int CNT_W  = 16,
  parameter int GOOD_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xt_in,
  input  logic [CNT_W-1:0]  timeout_cyc,
  input  logic [GOOD_W-1:0] good_need,
  output logic              tmo_evt,
  output logic              good_ok
);

  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [GOOD_W-1:0] GOOD_TOP = '1;

  logic [SYNC_N-1:0] sync_q;
  logic              last_q;
  logic              rise;
  logic [CNT_W-1:0]  gap_q;
  logic [GOOD_W-1:0] good_q;

  // synchroniser chain for the asynchronous crystal, SYNC_N >= 2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], xt_in};
      last_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise = sync_q[SYNC_N-1] & ~last_q;

  // cycles since the last accepted crystal edge, held at the timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (rise) begin
      gap_q <= '0;
    end else if (gap_q < timeout_cyc) begin
      gap_q <= gap_q + CNT_ONE;
    end
  end

  // one-shot: the cycle in which the gap would reach the timeout
  assign tmo_evt = ~rise & (gap_q == (timeout_cyc - CNT_ONE));

  // consecutive good edges since the last timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
    end else if (tmo_evt) begin
      good_q <= '0;
    end else if (rise && (good_q != GOOD_TOP)) begin
      good_q <= good_q + GOOD_W'(1);
    end
  end

  assign good_ok = (good_q >= good_need);

endmodule

// File: rtl/cfm_dco_limit.sv
module cfm_dco_limit #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAP_W-1:0] dco_tap,
  input  logic [TAP_W-1:0] tap_min,
  input  logic [TAP_W-1:0] tap_max,
  input  logic             clr_dco,
  output logic             dco_fault
);

  logic at_edge;
  logic flag_q;

  assign at_edge = (dco_tap <= tap_min) | (dco_tap >= tap_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (at_edge) begin
      flag_q <= 1'b1;
    end else if (clr_dco) begin
      flag_q <= 1'b0;
    end
  end

  assign dco_fault = flag_q;

endmodule

// File: rtl/cfm_fault_ctrl.sv
module cfm_fault_ctrl
  import clk_fault_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_evt,
  input  logic good_ok,
  input  logic clr_xt,
  input  logic clr_osc,
  input  logic dco_flag,
  input  logic irq_en,
  output logic xt_flag,
  output logic osc_flag,
  output logic use_ref,
  output logic irq
);

  src_flags_t src;
  logic       xt_q;
  logic       osc_q;
  logic       ref_q;

  assign src.xt  = xt_q;
  assign src.dco = dco_flag;

  // crystal flag: a timeout wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xt_q <= 1'b1;
    end else if (tmo_evt) begin
      xt_q <= 1'b1;
    end else if (clr_xt && good_ok) begin
      xt_q <= 1'b0;
    end
  end

  // combined flag: re-set every cycle while a source flag stands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b1;
    end else if (any_src(src)) begin
      osc_q <= 1'b1;
    end else if (clr_osc) begin
      osc_q <= 1'b0;
    end
  end

  // low-frequency path: enters fallback on crystal only, leaves on all clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b1;
    end else if (src.xt) begin
      ref_q <= 1'b1;
    end else if (!src.dco && !osc_q) begin
      ref_q <= 1'b0;
    end
  end

  assign xt_flag  = xt_q;
  assign osc_flag = osc_q;
  assign use_ref  = ref_q;
  assign irq      = irq_en & osc_q;

endmodule

// File: rtl/clk_fault_mon.sv
module clk_fault_mon #(
  parameter int CNT_W  = 16,
  parameter int GOOD_W = 8,
  parameter int TAP_W  = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xt_clk,
  input  logic              ref_clk,
  input  logic [TAP_W-1:0]  dco_tap,
  input  logic [TAP_W-1:0]  tap_min,
  input  logic [TAP_W-1:0]  tap_max,
  input  logic [CNT_W-1:0]  timeout_cyc,
  input  logic [GOOD_W-1:0] good_need,
  input  logic              clr_xt,
  input  logic              clr_dco,
  input  logic              clr_osc,
  input  logic              irq_en,
  output logic              xt_fault,
  output logic              dco_fault,
  output logic              osc_fault,
  output logic              fault_irq,
  output logic              lf_sel,
  output logic              lf_clk
);

  logic tmo_evt;
  logic good_ok;

  cfm_xt_watch #(
    .CNT_W (CNT_W),
    .GOOD_W(GOOD_W),
    .SYNC_N(SYNC_N)
  ) i_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .xt_in      (xt_clk),
    .timeout_cyc(timeout_cyc),
    .good_need  (good_need),
    .tmo_evt    (tmo_evt),
    .good_ok    (good_ok)
  );

  cfm_dco_limit #(
    .TAP_W(TAP_W)
  ) i_dco (
    .clk      (clk),
    .rst_n    (rst_n),
    .dco_tap  (dco_tap),
    .tap_min  (tap_min),
    .tap_max  (tap_max),
    .clr_dco  (clr_dco),
    .dco_fault(dco_fault)
  );

  cfm_fault_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmo_evt (tmo_evt),
    .good_ok (good_ok),
    .clr_xt  (clr_xt),
    .clr_osc (clr_osc),
    .dco_flag(dco_fault),
    .irq_en  (irq_en),
    .xt_flag (xt_fault),
    .osc_flag(osc_fault),
    .use_ref (lf_sel),
    .irq     (fault_irq)
  );

  // behavioural select only; a glitch-free cell replaces this in the clock tree
  assign lf_clk = lf_sel ? ref_clk : xt_clk;

endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAP_W-1:0] dco_tap,
  input logic [TAP_W-1:0] tap_min,
  input logic [TAP_W-1:0] tap_max,
  input logic             clr_xt,
  input logic             clr_dco,
  input logic             clr_osc,
  input logic             irq_en,
  input logic             xt_fault,
  input logic             dco_fault,
  input logic             osc_fault,
  input logic             fault_irq,
  input logic             lf_sel
);

  // R3
  xt_clear_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xt_fault) |-> $past(clr_xt));

  // R5
  dco_limit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dco_tap <= tap_min) || (dco_tap >= tap_max)) |=> dco_fault);

  // R5
  dco_clear_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dco_fault) |-> $past(clr_dco));

  // R6
  osc_follows_sources_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xt_fault || dco_fault) |=> osc_fault);

  // R6
  osc_clear_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_fault) |-> $past(clr_osc));

  // R7
  fallback_only_from_xt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lf_sel) |-> $past(xt_fault));

  // R8
  return_needs_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lf_sel) |-> $past(!xt_fault && !dco_fault && !osc_fault));

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_irq) |-> irq_en);

endmodule

bind clk_fault_mon cfm_checker #(.TAP_W(TAP_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dco_tap  (dco_tap),
  .tap_min  (tap_min),
  .tap_max  (tap_max),
  .clr_xt   (clr_xt),
  .clr_dco  (clr_dco),
  .clr_osc  (clr_osc),
  .irq_en   (irq_en),
  .xt_fault (xt_fault),
  .dco_fault(dco_fault),
  .osc_fault(osc_fault),
  .fault_irq(fault_irq),
  .lf_sel   (lf_sel)
);

// File: tb/test_clk_fault_mon.sv
`timescale 1ns/1ps
module test_clk_fault_mon;

  localparam int CNT_W = 16, GOOD_W = 8, TAP_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xt_clk = 1'b0;
  logic ref_clk = 1'b1;
  logic [TAP_W-1:0] dco_tap = 5'd15, tap_min = 5'd3, tap_max = 5'd28;
  logic [CNT_W-1:0] timeout_cyc = 16'd10;
  logic [GOOD_W-1:0] good_need = 8'd3;
  logic clr_xt = 1'b0, clr_dco = 1'b0, clr_osc = 1'b0, irq_en = 1'b1;
  logic xt_fault, dco_fault, osc_fault, fault_irq, lf_sel, lf_clk;

  int total = 0, fails = 0;
  int xt_per = 0;     // rise-to-rise spacing, <2 = stuck low
  int limit = -1;     // pulses per epoch, -1 = unlimited
  int epoch = 0;
  int seen_epoch = 0, emitted = 0, ph = 0;

  always #2.5 clk = ~clk;

  clk_fault_mon #(.CNT_W(CNT_W), .GOOD_W(GOOD_W), .TAP_W(TAP_W)) i_clk_fault_mon (
    .clk(clk), .rst_n(rst_n), .xt_clk(xt_clk), .ref_clk(ref_clk),
    .dco_tap(dco_tap), .tap_min(tap_min), .tap_max(tap_max),
    .timeout_cyc(timeout_cyc), .good_need(good_need),
    .clr_xt(clr_xt), .clr_dco(clr_dco), .clr_osc(clr_osc), .irq_en(irq_en),
    .xt_fault(xt_fault), .dco_fault(dco_fault), .osc_fault(osc_fault),
    .fault_irq(fault_irq), .lf_sel(lf_sel), .lf_clk(lf_clk));

  // crystal generator: one-cycle high pulse every xt_per cycles
  always @(negedge clk) begin
    if (epoch != seen_epoch) begin
      seen_epoch = epoch;
      emitted = 0;
    end
    if (xt_per < 2) begin
      xt_clk <= 1'b0;
    end else if (ph >= xt_per - 1) begin
      ph = 0;
      if (limit < 0 || emitted < limit) begin
        xt_clk <= 1'b1;
        emitted = emitted + 1;
      end else begin
        xt_clk <= 1'b0;
      end
    end else begin
      ph = ph + 1;
      xt_clk <= 1'b0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic strobe(input int which);
    case (which)
      0: clr_xt = 1'b1;
      1: clr_dco = 1'b1;
      default: clr_osc = 1'b1;
    endcase
    tick(1);
    clr_xt = 1'b0; clr_dco = 1'b0; clr_osc = 1'b0;
  endtask

  task automatic burst(input int n);
    limit = n;
    epoch++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1 xt_fault", xt_fault, 1'b1);
    chk("R1 dco_fault", dco_fault, 1'b0);
    chk("R1 osc_fault", osc_fault, 1'b1);
    chk("R1 lf_sel", lf_sel, 1'b1);
    chk("R1 fault_irq", fault_irq, 1'b1);
    chk("R10 lf_clk=ref", lf_clk, ref_clk);

    // R3 clear with no good edges is discarded
    strobe(0);
    chk("R3 clear without edges", xt_fault, 1'b1);
    xt_per = 3;
    tick(20);
    strobe(0);
    chk("R3 clear after edges", xt_fault, 1'b0);
    chk("R8 xt clear alone keeps ref", lf_sel, 1'b1);
    chk("R6 osc still set", osc_fault, 1'b1);
    strobe(2);
    chk("R6 osc cleared", osc_fault, 1'b0);
    tick(1);
    chk("R8 back to crystal", lf_sel, 1'b0);
    chk("R9 irq low", fault_irq, 1'b0);
    chk("R10 lf_clk=xt", lf_clk, xt_clk);

    // DCO faults
    dco_tap = 5'd3;
    tick(1);
    chk("R5 set at min", dco_fault, 1'b1);
    tick(1);
    chk("R6 osc from dco", osc_fault, 1'b1);
    chk("R7 dco keeps crystal", lf_sel, 1'b0);
    chk("R9 irq high", fault_irq, 1'b1);
    irq_en = 1'b0;
    #0.5;
    chk("R9 irq masked", fault_irq, 1'b0);
    irq_en = 1'b1;
    strobe(2);
    chk("R6 osc clear ignored", osc_fault, 1'b1);
    strobe(1);
    chk("R5 clear ignored at limit", dco_fault, 1'b1);
    dco_tap = 5'd15;
    strobe(1);
    chk("R5 clear in range", dco_fault, 1'b0);
    dco_tap = 5'd28;
    tick(1);
    chk("R5 set at max", dco_fault, 1'b1);
    dco_tap = 5'd15;
    for (int t = 0; t < 32; t++) begin
      dco_tap = TAP_W'(t);
      tick(1);
      chk($sformatf("R5 tap %0d", t), dco_fault, (t <= 3 || t >= 28));
      dco_tap = 5'd15;
      strobe(1);
    end
    strobe(2);
    chk("R6 osc cleared after dco", osc_fault, 1'b0);
    chk("R7 crystal held through dco", lf_sel, 1'b0);

    // both sources at fault
    xt_per = 0;
    tick(15);
    chk("R2 stuck crystal", xt_fault, 1'b1);
    chk("R2 fallback", lf_sel, 1'b1);
    chk("R10 lf_clk=ref", lf_clk, ref_clk);
    ref_clk = 1'b0;
    #0.5;
    chk("R10 lf_clk follows ref", lf_clk, 1'b0);
    ref_clk = 1'b1;
    dco_tap = 5'd3;
    xt_per = 3;
    tick(20);
    strobe(0);
    chk("R3 xt cleared", xt_fault, 1'b0);
    strobe(2);
    chk("R6 dco holds osc", osc_fault, 1'b1);
    tick(2);
    chk("R8 dco holds ref", lf_sel, 1'b1);
    dco_tap = 5'd15;
    strobe(1);
    strobe(2);
    tick(1);
    chk("R8 all clear returns", lf_sel, 1'b0);

    // R3 threshold sweep, no pending clears
    timeout_cyc = 16'd12;
    for (int n = 0; n <= 5; n++) begin
      burst(0);
      tick(20);
      burst(n);
      tick(3 * n + 4);
      strobe(0);
      chk($sformatf("R3 %0d edges", n), xt_fault, (n < 3));
      if (n == 2) begin
        burst(2);
        tick(10);
        chk("R3 no pending clear", xt_fault, 1'b1);
        strobe(0);
        chk("R3 later clear", xt_fault, 1'b0);
      end
    end

    // R4 timeout restarts the good count
    burst(0);
    tick(20);
    burst(2);
    tick(10);
    burst(0);
    tick(20);
    burst(2);
    tick(10);
    strobe(0);
    chk("R4 count restarted", xt_fault, 1'b1);
    burst(1);
    tick(6);
    strobe(0);
    chk("R4 third edge after timeout", xt_fault, 1'b0);

    // R2 spacing sweep around the timeout
    timeout_cyc = 16'd6;
    for (int p = 2; p <= 12; p++) begin
      burst(-1);
      xt_per = 3;
      tick(20);
      strobe(0);
      strobe(2);
      tick(1);
      chk($sformatf("R8 recovered before P=%0d", p), lf_sel, 1'b0);
      xt_per = p;
      tick(6 * p + 12);
      chk($sformatf("R2 flag P=%0d", p), xt_fault, (p > 6));
      chk($sformatf("R2 select P=%0d", p), lf_sel, (p > 6));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule